// File: doc/BRIEF.md
# Per-Phase Commutation Gating Controller

This block decides, for each phase of a static transfer switch, when the gate enables move from the preferred-feeder thyristor pair to the alternate-feeder pair and back again. A sag detector outside the block raises a transfer request. From then on, each phase watches its own signed samples of preferred voltage, alternate voltage and preferred line current. A phase fires its alternate pair only when the sign and magnitude relations show that the preferred device now conducting can turn off. This keeps cross current from flowing between the two feeders.

Phases act independently, so different phases can move at different samples. When the request is withdrawn, every alternate enable drops together. Each phase then hands back to its preferred pair at its own next current zero crossing. The voltage margins and the current dead-band are inputs, so firmware can tune them. RMS detection and pulse-train generation are outside this block.

Top module: `commutation_gate_ctrl`

## Requirements
- R1: After reset every phase has its preferred enable high, its alternate enable low and its transferred flag low.
- R2: With the request high and a phase on its preferred pair, if that phase's preferred voltage, alternate voltage and current share one sign (sign is the sample's MSB) and |Vp|−|Va| is strictly greater than `dv1_min`, the alternate enable rises on the next clock edge. A difference equal to the margin does not fire.
- R3: Each phase moves on its own conditions only. In the same cycle one phase may fire while another keeps waiting.
- R4: If the signs agree but the R2 margin is not met, the phase waits for a current zero crossing. At that crossing it fires if |Vp|−|Va| > 0.
- R5: If at that crossing the difference is not positive but all three signs still agree, the phase fires at the first later sample where the signs agree and |Vp|−|Va| > 0. A difference of zero does not fire.
- R6: If the alternate voltage and the current share a sign and the preferred voltage has the other sign, the phase fires once |Vp−Va| is strictly greater than `dv2_min`.
- R7: A phase never has both enables high. When the alternate enable rises, the preferred enable falls on that same edge.
- R8: The edge that samples the request low clears every alternate enable.
- R9: After the request drops, a fired phase keeps both enables low until its current crosses zero. A crossing is a sign change from the previous sample, or |I| < `zc_band`. The preferred enable rises on the edge that samples the crossing.
- R10: If the request drops before a phase has fired, that phase returns to its idle preferred state. It is then free to fire again on R2 alone, without waiting for a crossing.
- R11: The transferred flag is high from the edge that fires the alternate pair until the edge that hands back to the preferred pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Transfer request, high = move to alternate feeder |
| v_pref | input | NPH*W | Signed preferred voltage samples, phase p at bits p*W +: W |
| v_alt | input | NPH*W | Signed alternate voltage samples |
| i_pref | input | NPH*W | Signed preferred line current samples |
| dv1_min | input | W | Same-sign magnitude margin |
| dv2_min | input | W | Opposite-sign difference margin |
| zc_band | input | W | Current dead-band that counts as a zero crossing |
| pref_en | output | NPH | Preferred pair gate enable per phase |
| alt_en | output | NPH | Alternate pair deblock / gate enable per phase |
| xferred | output | NPH | Phase is off its preferred pair |

## Verification
Some properties are checked by assertions on every cycle: the two enables of a phase are never high together, the alternate enable only rises after a cycle with the request high and clears right after the request falls, and the transferred flag stays high while a phase is between pairs. The bench scenarios are what show which sample a phase fires on. They cover strict versus equal margins, firing on a crossing versus a later positive difference, crossings caught by the dead-band versus by a sign change, and an aborted wait that can refire without a crossing.

// File: rtl/commutation_gate_ctrl.sv
module commutation_gate_ctrl #(
  parameter int NPH = 3,
  parameter int W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_req,
  input  logic [NPH*W-1:0] v_pref,
  input  logic [NPH*W-1:0] v_alt,
  input  logic [NPH*W-1:0] i_pref,
  input  logic [W-1:0]     dv1_min,
  input  logic [W-1:0]     dv2_min,
  input  logic [W-1:0]     zc_band,
  output logic [NPH-1:0]   pref_en,
  output logic [NPH-1:0]   alt_en,
  output logic [NPH-1:0]   xferred
);

  typedef enum logic [2:0] {
    ON_PREF, WAIT_ZC, WAIT_POSDIFF, ON_ALT, RET_WAIT_ZC
  } ph_state_t;

  localparam int MW = W + 2;

  genvar p;
  generate
    for (p = 0; p < NPH; p++) begin : g_ph
      logic [W-1:0]  vp, va, ip, ip_q;
      logic [W:0]    mag_vp, mag_va, mag_ip;
      logic [MW-1:0] gap, sep, sep_mag;
      logic          same_sign, oppose, gap_pos, fire_i, fire_iv, zc;
      ph_state_t     st, st_nx;

      assign vp = v_pref[p*W +: W];
      assign va = v_alt[p*W +: W];
      assign ip = i_pref[p*W +: W];

      assign mag_vp = vp[W-1] ? ((W+1)'(0) - {1'b1, vp}) : {1'b0, vp};
      assign mag_va = va[W-1] ? ((W+1)'(0) - {1'b1, va}) : {1'b0, va};
      assign mag_ip = ip[W-1] ? ((W+1)'(0) - {1'b1, ip}) : {1'b0, ip};

      assign gap     = {1'b0, mag_vp} - {1'b0, mag_va};
      assign sep     = {{2{vp[W-1]}}, vp} - {{2{va[W-1]}}, va};
      assign sep_mag = sep[MW-1] ? (MW'(0) - sep) : sep;

      assign same_sign = (vp[W-1] == va[W-1]) && (va[W-1] == ip[W-1]);
      assign oppose    = (va[W-1] == ip[W-1]) && (vp[W-1] != va[W-1]);
      assign gap_pos   = !gap[MW-1] && (gap != MW'(0));
      assign fire_i    = same_sign && gap_pos && (gap > {2'b00, dv1_min});
      assign fire_iv   = oppose && (sep_mag > {2'b00, dv2_min});
      assign zc        = (ip[W-1] != ip_q[W-1]) || (mag_ip < {1'b0, zc_band});

      always_comb begin
        st_nx = st;
        unique case (st)
          ON_PREF:
            if (xfer_req) begin
              if (fire_i || fire_iv) st_nx = ON_ALT;
              else if (same_sign)    st_nx = WAIT_ZC;
            end
          WAIT_ZC:
            if (!xfer_req) st_nx = ON_PREF;
            else if (zc) begin
              if (gap_pos)        st_nx = ON_ALT;
              else if (same_sign) st_nx = WAIT_POSDIFF;
              else                st_nx = ON_PREF;
            end
          WAIT_POSDIFF:
            if (!xfer_req)               st_nx = ON_PREF;
            else if (!same_sign)         st_nx = ON_PREF;
            else if (gap_pos)            st_nx = ON_ALT;
          ON_ALT:
            if (!xfer_req) st_nx = RET_WAIT_ZC;
          RET_WAIT_ZC:
            if (zc) st_nx = ON_PREF;
          default: st_nx = ON_PREF;
        endcase
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st   <= ON_PREF;
          ip_q <= '0;
        end else begin
          st   <= st_nx;
          ip_q <= ip;
        end
      end

      assign pref_en[p] = (st == ON_PREF) || (st == WAIT_ZC) || (st == WAIT_POSDIFF);
      assign alt_en[p]  = (st == ON_ALT);
      assign xferred[p] = (st == ON_ALT) || (st == RET_WAIT_ZC);

      assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pref_en[p] && alt_en[p]));
      assert_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alt_en[p]) |-> $fell(pref_en[p]));
      assert_fire_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alt_en[p]) |-> $past(xfer_req));
      assert_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req |=> !alt_en[p]);
      assert_flag_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xferred[p] && !alt_en[p]) |-> !pref_en[p]);
      assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en[p] |-> xferred[p]);
    end
  endgenerate

endmodule

// File: tb/commutation_gate_ctrl_test.sv
module commutation_gate_ctrl_test;
  localparam int NPH = 3;
  localparam int W   = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic xfer_req = 0;
  logic [NPH*W-1:0] v_pref = '0, v_alt = '0, i_pref = '0;
  logic [W-1:0] dv1_min = 16'd20, dv2_min = 16'd30, zc_band = 16'd5;
  logic [NPH-1:0] pref_en, alt_en, xferred;

  always #2.5 clk = ~clk;

  commutation_gate_ctrl #(.NPH(NPH), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req),
    .v_pref(v_pref), .v_alt(v_alt), .i_pref(i_pref),
    .dv1_min(dv1_min), .dv2_min(dv2_min), .zc_band(zc_band),
    .pref_en(pref_en), .alt_en(alt_en), .xferred(xferred));

  typedef struct {
    logic [NPH-1:0] pref;
    logic [NPH-1:0] alt;
    logic [NPH-1:0] xf;
    string          tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int avp[NPH], ava[NPH], aip[NPH];
  bit done = 0;

  task automatic ph(input int p, input int vp, input int va, input int ip);
    avp[p] = vp; ava[p] = va; aip[p] = ip;
  endtask

  task automatic drive_pins(input bit req);
    xfer_req = req;
    for (int p = 0; p < NPH; p++) begin
      v_pref[p*W +: W] = W'(avp[p]);
      v_alt[p*W +: W]  = W'(ava[p]);
      i_pref[p*W +: W] = W'(aip[p]);
    end
  endtask

  task automatic apply(input bit req, input logic [NPH-1:0] ep, input logic [NPH-1:0] ea,
                       input logic [NPH-1:0] ex, input string tag);
    exp_t it;
    @(negedge clk);
    drive_pins(req);
    it.pref = ep; it.alt = ea; it.xf = ex; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (pref_en !== it.pref || alt_en !== it.alt || xferred !== it.xf) begin
        fails++;
        $display("FAIL %s: pref/alt/xf actual %b/%b/%b expected %b/%b/%b",
                 it.tag, pref_en, alt_en, xferred, it.pref, it.alt, it.xf);
      end
    end
  end

  initial begin
    for (int p = 0; p < NPH; p++) ph(p, 100, 100, 50);
    drive_pins(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    apply(0, 3'b111, 3'b000, 3'b000, "R1 reset state");
    // phase0 condition I, phase1 waits, phase2 condition IV
    ph(0, 100, 50, 40); ph(1, 100, 90, 40); ph(2, -100, 50, 40);
    apply(1, 3'b010, 3'b101, 3'b101, "R2 R3 R6 mixed firing");
    apply(1, 3'b010, 3'b101, 3'b101, "R4 no crossing keeps waiting");
    ph(1, 100, 90, -40);
    apply(1, 3'b000, 3'b111, 3'b111, "R4 fire at sign-change crossing");
    apply(0, 3'b000, 3'b000, 3'b111, "R8 request drop clears alternate");
    ph(0, 100, 50, 2);
    apply(0, 3'b001, 3'b000, 3'b110, "R9 dead-band crossing returns phase0");
    ph(1, 100, 90, 30);
    apply(0, 3'b011, 3'b000, 3'b100, "R9 sign crossing returns phase1");
    ph(2, -100, 50, -40);
    apply(0, 3'b111, 3'b000, 3'b000, "R9 R11 all phases back");
    // condition III path on phase0, margin boundaries on the others
    ph(0, 100, 90, 40); ph(1, 100, -90, 40); ph(2, -15, 15, 10);
    apply(1, 3'b111, 3'b000, 3'b000, "R6 equal margin does not fire");
    ph(0, -80, -90, -40);
    apply(1, 3'b111, 3'b000, 3'b000, "R5 crossing with negative difference waits");
    ph(0, -90, -90, -40);
    apply(1, 3'b111, 3'b000, 3'b000, "R5 zero difference does not fire");
    ph(0, -91, -90, -40);
    apply(1, 3'b110, 3'b001, 3'b001, "R5 first positive difference fires");
    ph(2, -16, 15, 10);
    apply(1, 3'b010, 3'b101, 3'b101, "R6 margin exceeded fires");
    ph(1, 100, 80, 40);
    apply(1, 3'b010, 3'b101, 3'b101, "R2 equal margin does not fire");
    apply(0, 3'b010, 3'b000, 3'b101, "R8 R10 drop during wait");
    ph(1, 100, 79, 40);
    apply(1, 3'b000, 3'b010, 3'b111, "R10 aborted phase refires without crossing");
    ph(0, -91, -90, -3);
    apply(1, 3'b001, 3'b010, 3'b110, "R9 return waits for crossing only");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule